// File: doc/BRIEF.md
# Class-of-Service Memory Command Arbiter

This block holds up to eight pending memory commands and chooses, each cycle, which one goes to the memory controller next. Every command carries a tag, a connection ID and a 3-bit priority, where 0 is the most urgent. Each command is placed in up to two service classes. Membership comes either from a programmable priority-to-class bitmap or from connection-ID match rules. There are three rules per class, and each rule is an ID value with a count of low bits to ignore.

Every queued command has a wait counter that ages it. When the counter reaches the threshold of a class the command belongs to, the command takes precedence over plain priority order. The oldest entry in the queue has a separate age limit. Once that limit is reached, the oldest entry wins outright, so that a stream of urgent traffic cannot block it forever. The controller takes a grant by raising `gnt_ready`, and the granted entry leaves the queue on that clock edge.

Top module: `cos_cmd_arbiter`

## Requirements
- R1: After reset the queue is empty: `gnt_valid` is 0 and `enq_ready` is 1.
- R2: When no entry has expired, the grant goes to the lowest priority value (0 is most urgent). Between entries of equal priority, the one enqueued first wins. `gnt_kind` is 0 in this case.
- R3: Bit `2*p+c` of `cfg_pri_map` places priority `p` in class `c` (class 0 or 1). An entry whose wait count is at or above its class threshold (`cfg_thr0` or `cfg_thr1`) is granted ahead of entries that have not expired, with `gnt_kind` = 1.
- R4: Rule `r` of class `c` uses enable bit `c*3+r`, the 8-bit ID at `cfg_rule_val[(c*3+r)*8 +: 8]` and the 4-bit mask at `cfg_rule_mask[(c*3+r)*4 +: 4]`. A mask value of N ignores the N least significant ID bits. For example, ID 0xFF with mask 3 matches 0xF8 through 0xFF but not 0xF7, and mask 8 matches every ID.
- R5: An entry that belongs to both classes expires at the smaller of the two thresholds.
- R6: When several entries have expired, the one with the lowest priority value is granted first. Among those, the oldest wins.
- R7: When the oldest entry's wait count is at or above `cfg_old_thr`, that entry is granted first regardless of class or priority, with `gnt_kind` = 2.
- R8: An entry that belongs to no class never expires by class, even when both thresholds are 0.
- R9: At most one entry leaves per cycle, and only on a clock edge where `gnt_ready` and `gnt_valid` are both 1. While `gnt_ready` is 0 the grant holds steady.
- R10: With eight entries queued, `enq_ready` is 0 and an enqueue attempt is dropped.
- R11: Wait counters go up by one per cycle while queued and saturate at 255 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_tag | input | 4 | Tag of the new command |
| enq_cid | input | 8 | Connection ID of the new command |
| enq_pri | input | 3 | Priority of the new command, 0 most urgent |
| enq_ready | output | 1 | Queue has a free slot |
| cfg_thr0 | input | 8 | Class 0 latency threshold |
| cfg_thr1 | input | 8 | Class 1 latency threshold |
| cfg_old_thr | input | 8 | Oldest-entry age limit |
| cfg_pri_map | input | 16 | Priority-to-class bitmap, bit 2*p+c |
| cfg_rule_en | input | 6 | Rule enables, bit c*3+r |
| cfg_rule_val | input | 48 | Rule ID values, 8 bits per rule |
| cfg_rule_mask | input | 24 | Rule ignored-low-bit counts, 4 bits per rule |
| gnt_ready | input | 1 | Consumer takes the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_tag | output | 4 | Tag of the granted command |
| gnt_kind | output | 2 | 0 plain priority, 1 class expiry, 2 oldest override |

## Verification
Two rules can apply in the same cycle: the oldest-entry override and class expiry. To provoke this, the bench queues a slow unclassed command first and a classed command behind it. The classed command expires within a cycle. The bench then waits until the first command also reaches the age limit, so both rules hold at once. The test passes only if the grant moves from the younger expired command (kind 1) to the oldest one (kind 2) on exactly the cycle the age limit is reached.

// File: rtl/cos_arb_pkg.sv
package cos_arb_pkg;
  typedef enum logic [1:0] {
    GK_PLAIN  = 2'd0,
    GK_CLASS  = 2'd1,
    GK_OLDEST = 2'd2
  } gnt_kind_e;

  localparam int NCLS = 2;
endpackage

// File: rtl/cos_classifier.sv
module cos_classifier #(
  parameter int CID_W  = 8,
  parameter int PRI_W  = 3,
  parameter int AGE_W  = 8,
  parameter int RULES  = 3,
  parameter int MASK_W = 4
) (
  input  logic                          valid,
  input  logic [CID_W-1:0]              cid,
  input  logic [PRI_W-1:0]              pri,
  input  logic [AGE_W-1:0]              age,
  input  logic [2*(2**PRI_W)-1:0]       pri_map,
  input  logic [2*RULES-1:0]            rule_en,
  input  logic [2*RULES*CID_W-1:0]      rule_val,
  input  logic [2*RULES*MASK_W-1:0]     rule_mask,
  input  logic [AGE_W-1:0]              thr0,
  input  logic [AGE_W-1:0]              thr1,
  output logic                          expired
);
  logic [1:0]       member;
  logic [AGE_W-1:0] eff_thr;

  function automatic logic id_hit(input logic [CID_W-1:0] a,
                                  input logic [CID_W-1:0] b,
                                  input logic [MASK_W-1:0] m);
    logic [CID_W-1:0] diff;
    diff = a ^ b;
    return (diff >> m) == '0;
  endfunction

  function automatic logic [AGE_W-1:0] min_thr(input logic [AGE_W-1:0] x,
                                               input logic [AGE_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      member[c] = pri_map[int'(pri) * 2 + c];
      for (int r = 0; r < RULES; r++) begin
        if (rule_en[c*RULES + r] &&
            id_hit(cid, rule_val[(c*RULES + r)*CID_W +: CID_W],
                   rule_mask[(c*RULES + r)*MASK_W +: MASK_W]))
          member[c] = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (member)
      2'b01:   eff_thr = thr0;
      2'b10:   eff_thr = thr1;
      2'b11:   eff_thr = min_thr(thr0, thr1);
      default: eff_thr = '1;
    endcase
  end

  assign expired = valid && (member != 2'b00) && (age >= eff_thr);
endmodule

// File: rtl/cos_pick.sv
module cos_pick #(
  parameter int N     = 8,
  parameter int PRI_W = 3,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]       cand,
  input  logic [N*PRI_W-1:0] pri_flat,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [PRI_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i] && (!any || pri_flat[i*PRI_W +: PRI_W] <= best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = pri_flat[i*PRI_W +: PRI_W];
      end
    end
  end
endmodule

// File: rtl/cos_queue.sv
module cos_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int CID_W = 8,
  parameter int PRI_W = 3,
  parameter int AGE_W = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enq_fire,
  input  logic [TAG_W-1:0]         enq_tag,
  input  logic [CID_W-1:0]         enq_cid,
  input  logic [PRI_W-1:0]         enq_pri,
  input  logic                     gnt_fire,
  input  logic [IDX_W-1:0]         gnt_idx,
  output logic [DEPTH-1:0]         valid,
  output logic [DEPTH*TAG_W-1:0]   tag_flat,
  output logic [DEPTH*CID_W-1:0]   cid_flat,
  output logic [DEPTH*PRI_W-1:0]   pri_flat,
  output logic [DEPTH*AGE_W-1:0]   age_flat,
  output logic [CNT_W-1:0]         count
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CID_W-1:0] cid_q [DEPTH];
  logic [PRI_W-1:0] pri_q [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [TAG_W-1:0] tag_n [DEPTH];
  logic [CID_W-1:0] cid_n [DEPTH];
  logic [PRI_W-1:0] pri_n [DEPTH];
  logic [AGE_W-1:0] age_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;

  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (a == '1) ? a : a + 1'b1;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = i + ((gnt_fire && i >= int'(gnt_idx)) ? 1 : 0);
      if (src < DEPTH) begin
        tag_n[i] = tag_q[src];
        cid_n[i] = cid_q[src];
        pri_n[i] = pri_q[src];
        age_n[i] = age_step(age_q[src]);
      end else begin
        tag_n[i] = '0;
        cid_n[i] = '0;
        pri_n[i] = '0;
        age_n[i] = '0;
      end
    end
    cnt_n = cnt_q - CNT_W'(gnt_fire);
    if (enq_fire) begin
      tag_n[IDX_W'(cnt_n)] = enq_tag;
      cid_n[IDX_W'(cnt_n)] = enq_cid;
      pri_n[IDX_W'(cnt_n)] = enq_pri;
      age_n[IDX_W'(cnt_n)] = '0;
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        cid_q[i] <= '0;
        pri_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= tag_n[i];
        cid_q[i] <= cid_n[i];
        pri_q[i] <= pri_n[i];
        age_q[i] <= age_n[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign valid[g]                    = CNT_W'(g) < cnt_q;
    assign tag_flat[g*TAG_W +: TAG_W]  = tag_q[g];
    assign cid_flat[g*CID_W +: CID_W]  = cid_q[g];
    assign pri_flat[g*PRI_W +: PRI_W]  = pri_q[g];
    assign age_flat[g*AGE_W +: AGE_W]  = age_q[g];
  end

  assign count = cnt_q;
endmodule

// File: rtl/cos_cmd_arbiter.sv
module cos_cmd_arbiter
  import cos_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int CID_W = 8,
  parameter int PRI_W = 3,
  parameter int AGE_W = 8,
  parameter int RULES = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enq_valid,
  input  logic [TAG_W-1:0]               enq_tag,
  input  logic [CID_W-1:0]               enq_cid,
  input  logic [PRI_W-1:0]               enq_pri,
  output logic                           enq_ready,
  input  logic [AGE_W-1:0]               cfg_thr0,
  input  logic [AGE_W-1:0]               cfg_thr1,
  input  logic [AGE_W-1:0]               cfg_old_thr,
  input  logic [NCLS*(2**PRI_W)-1:0]     cfg_pri_map,
  input  logic [NCLS*RULES-1:0]          cfg_rule_en,
  input  logic [NCLS*RULES*CID_W-1:0]    cfg_rule_val,
  input  logic [NCLS*RULES*$clog2(CID_W+1)-1:0] cfg_rule_mask,
  input  logic                           gnt_ready,
  output logic                           gnt_valid,
  output logic [TAG_W-1:0]               gnt_tag,
  output logic [1:0]                     gnt_kind
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MASK_W = $clog2(CID_W + 1);

  logic [DEPTH-1:0]       valid;
  logic [DEPTH*TAG_W-1:0] tag_flat;
  logic [DEPTH*CID_W-1:0] cid_flat;
  logic [DEPTH*PRI_W-1:0] pri_flat;
  logic [DEPTH*AGE_W-1:0] age_flat;
  logic [CNT_W-1:0]       count;
  logic [DEPTH-1:0]       expired;
  logic                   old_hit, exp_any, all_any;
  logic [IDX_W-1:0]       exp_idx, all_idx, gnt_idx;
  logic                   enq_fire, gnt_fire;
  gnt_kind_e              kind;

  assign enq_ready = count < CNT_W'(DEPTH);
  assign enq_fire  = enq_valid && enq_ready;
  assign gnt_valid = valid[0];
  assign gnt_fire  = gnt_valid && gnt_ready;

  cos_queue #(
    .DEPTH(DEPTH), .TAG_W(TAG_W), .CID_W(CID_W), .PRI_W(PRI_W),
    .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq_fire(enq_fire), .enq_tag(enq_tag), .enq_cid(enq_cid), .enq_pri(enq_pri),
    .gnt_fire(gnt_fire), .gnt_idx(gnt_idx),
    .valid(valid), .tag_flat(tag_flat), .cid_flat(cid_flat),
    .pri_flat(pri_flat), .age_flat(age_flat), .count(count)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cls
    cos_classifier #(
      .CID_W(CID_W), .PRI_W(PRI_W), .AGE_W(AGE_W), .RULES(RULES), .MASK_W(MASK_W)
    ) u_cls (
      .valid(valid[g]),
      .cid(cid_flat[g*CID_W +: CID_W]),
      .pri(pri_flat[g*PRI_W +: PRI_W]),
      .age(age_flat[g*AGE_W +: AGE_W]),
      .pri_map(cfg_pri_map), .rule_en(cfg_rule_en),
      .rule_val(cfg_rule_val), .rule_mask(cfg_rule_mask),
      .thr0(cfg_thr0), .thr1(cfg_thr1),
      .expired(expired[g])
    );
  end

  cos_pick #(.N(DEPTH), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_pick_exp (
    .cand(expired), .pri_flat(pri_flat), .any(exp_any), .idx(exp_idx)
  );

  cos_pick #(.N(DEPTH), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_pick_all (
    .cand(valid), .pri_flat(pri_flat), .any(all_any), .idx(all_idx)
  );

  assign old_hit = valid[0] && (age_flat[AGE_W-1:0] >= cfg_old_thr);

  always_comb begin
    if (old_hit) begin
      gnt_idx = '0;
      kind    = GK_OLDEST;
    end else if (exp_any) begin
      gnt_idx = exp_idx;
      kind    = GK_CLASS;
    end else if (all_any) begin
      gnt_idx = all_idx;
      kind    = GK_PLAIN;
    end else begin
      gnt_idx = '0;
      kind    = GK_PLAIN;
    end
  end

  assign gnt_kind = kind;
  assign gnt_tag  = tag_flat[gnt_idx*TAG_W +: TAG_W];
endmodule

// File: rtl/cos_arb_checker.sv
module cos_arb_checker #(
  parameter int DEPTH = 8,
  parameter int PRI_W = 3,
  parameter int AGE_W = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [DEPTH-1:0]       valid,
  input logic [DEPTH*PRI_W-1:0] pri_flat,
  input logic [DEPTH*AGE_W-1:0] age_flat,
  input logic [DEPTH-1:0]       expired,
  input logic [AGE_W-1:0]       old_thr,
  input logic                   gnt_valid,
  input logic [IDX_W-1:0]       gnt_idx,
  input logic [1:0]             gnt_kind,
  input logic                   gnt_fire,
  input logic                   enq_fire,
  input logic [CNT_W-1:0]       count
);
  logic             better_exp, better_all;
  logic [PRI_W-1:0] gpri;
  logic [AGE_W-1:0] age0;

  assign gpri = pri_flat[gnt_idx*PRI_W +: PRI_W];
  assign age0 = age_flat[AGE_W-1:0];

  always_comb begin
    better_exp = 1'b0;
    better_all = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (expired[i] && pri_flat[i*PRI_W +: PRI_W] < gpri) better_exp = 1'b1;
      if (valid[i] && pri_flat[i*PRI_W +: PRI_W] < gpri)   better_all = 1'b1;
    end
  end

  assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !gnt_valid);

  assert_plain_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_kind == 2'd0) |-> (!better_all && expired == '0));

  assert_expired_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && expired != '0 && gnt_kind != 2'd2) |-> (gnt_kind == 2'd1 && expired[gnt_idx]));

  assert_expired_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_kind == 2'd1) |-> !better_exp);

  assert_oldest_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid[0] && age0 >= old_thr) |-> (gnt_idx == '0 && gnt_kind == 2'd2));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == CNT_W'($past(count) + CNT_W'($past(enq_fire)) - CNT_W'($past(gnt_fire))));

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !enq_fire);

  assert_age_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid[0] && age0 == '1 && !gnt_fire) |=> (age0 == '1));
endmodule

bind cos_cmd_arbiter cos_arb_checker #(
  .DEPTH(DEPTH), .PRI_W(PRI_W), .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .valid(valid), .pri_flat(pri_flat),
  .age_flat(age_flat), .expired(expired), .old_thr(cfg_old_thr),
  .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_kind(gnt_kind),
  .gnt_fire(gnt_fire), .enq_fire(enq_fire), .count(count)
);

// File: tb/cos_cmd_arbiter_tb_top.sv
`timescale 1ns/1ps
module cos_cmd_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0;
  logic [3:0]  enq_tag = '0;
  logic [7:0]  enq_cid = '0;
  logic [2:0]  enq_pri = '0;
  logic        enq_ready;
  logic [7:0]  cfg_thr0, cfg_thr1, cfg_old_thr;
  logic [15:0] cfg_pri_map;
  logic [5:0]  cfg_rule_en;
  logic [47:0] cfg_rule_val;
  logic [23:0] cfg_rule_mask;
  logic        gnt_ready = 1'b0;
  logic        gnt_valid;
  logic [3:0]  gnt_tag;
  logic [1:0]  gnt_kind;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cos_cmd_arbiter dut_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_tag(enq_tag), .enq_cid(enq_cid), .enq_pri(enq_pri),
    .enq_ready(enq_ready),
    .cfg_thr0(cfg_thr0), .cfg_thr1(cfg_thr1), .cfg_old_thr(cfg_old_thr),
    .cfg_pri_map(cfg_pri_map), .cfg_rule_en(cfg_rule_en),
    .cfg_rule_val(cfg_rule_val), .cfg_rule_mask(cfg_rule_mask),
    .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_tag(gnt_tag), .gnt_kind(gnt_kind)
  );

  // {cid, rule id, mask, expected hit}
  localparam logic [20:0] ID_VEC [8] = '{
    {8'hF8, 8'hFF, 4'd3, 1'b1},
    {8'hFF, 8'hFF, 4'd3, 1'b1},
    {8'hF7, 8'hFF, 4'd3, 1'b0},
    {8'h3C, 8'h3C, 4'd0, 1'b1},
    {8'h3D, 8'h3C, 4'd0, 1'b0},
    {8'h12, 8'h00, 4'd8, 1'b1},
    {8'h80, 8'h00, 4'd7, 1'b0},
    {8'h7F, 8'h00, 4'd7, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_default();
    cfg_thr0 = 8'd255; cfg_thr1 = 8'd255; cfg_old_thr = 8'd255;
    cfg_pri_map = '0; cfg_rule_en = '0; cfg_rule_val = '0; cfg_rule_mask = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enq_valid = 1'b0; gnt_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic [3:0] t, input logic [7:0] c, input logic [2:0] p);
    enq_valid = 1'b1; enq_tag = t; enq_cid = c; enq_pri = p;
    @(posedge clk);
    #1 enq_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take_one();
    gnt_ready = 1'b1;
    @(posedge clk);
    #1 gnt_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cfg_default();
    do_reset();
    // R1 reset state
    chk("R1", gnt_valid, 0);
    chk("R1", enq_ready, 1);

    // R4 table of connection-ID match rules, class 0 rule 0
    for (int v = 0; v < 8; v++) begin
      logic [7:0] c, rv;
      logic [3:0] m;
      logic hit;
      {c, rv, m, hit} = ID_VEC[v];
      cfg_default();
      cfg_thr0 = 8'd2; cfg_rule_en = 6'b000001;
      cfg_rule_val[7:0] = rv; cfg_rule_mask[3:0] = m;
      do_reset();
      push(4'd9, c, 3'd7);
      wait_cyc(4);
      chk("R4", gnt_tag, 9);
      chk("R4", gnt_kind, hit ? 1 : 0);
    end

    // R2 plain priority with older tie-break, R9 stall and one removal per edge
    cfg_default(); do_reset();
    push(4'd1, 8'h00, 3'd3);
    push(4'd2, 8'h00, 3'd1);
    push(4'd3, 8'h00, 3'd1);
    push(4'd4, 8'h00, 3'd5);
    chk("R2", gnt_tag, 2);
    chk("R2", gnt_kind, 0);
    wait_cyc(5);
    chk("R9", gnt_tag, 2);
    take_one();
    chk("R9", gnt_tag, 3);
    take_one();
    chk("R2", gnt_tag, 1);
    take_one();
    chk("R2", gnt_tag, 4);
    take_one();
    chk("R9", gnt_valid, 0);

    // R3 class by priority map: pri 6 in class 1 (bit 13)
    cfg_default(); cfg_pri_map = 16'h2000; cfg_thr1 = 8'd3; do_reset();
    push(4'd1, 8'h00, 3'd0);
    push(4'd2, 8'h00, 3'd6);
    wait_cyc(1);
    chk("R3", gnt_tag, 1);
    chk("R3", gnt_kind, 0);
    wait_cyc(2);
    chk("R3", gnt_tag, 2);
    chk("R3", gnt_kind, 1);

    // R5 dual membership uses smaller threshold
    cfg_default(); cfg_pri_map = 16'h2000; cfg_thr1 = 8'd10; cfg_thr0 = 8'd2;
    cfg_rule_en = 6'b000001; cfg_rule_val[7:0] = 8'h55; do_reset();
    push(4'd1, 8'h00, 3'd0);
    push(4'd2, 8'h55, 3'd6);
    wait_cyc(3);
    chk("R5", gnt_tag, 2);
    chk("R5", gnt_kind, 1);
    do_reset();
    push(4'd1, 8'h00, 3'd0);
    push(4'd2, 8'h56, 3'd6);
    wait_cyc(3);
    chk("R5", gnt_tag, 1);
    wait_cyc(7);
    chk("R5", gnt_tag, 2);
    chk("R5", gnt_kind, 1);

    // R6 several expired: lowest priority value first
    cfg_default(); cfg_pri_map = 16'h0110; cfg_thr0 = 8'd1; do_reset();
    push(4'd5, 8'h00, 3'd4);
    push(4'd6, 8'h00, 3'd2);
    push(4'd7, 8'h00, 3'd0);
    wait_cyc(2);
    chk("R6", gnt_tag, 6);
    chk("R6", gnt_kind, 1);
    take_one();
    chk("R6", gnt_tag, 5);
    take_one();
    chk("R6", gnt_tag, 7);
    chk("R6", gnt_kind, 0);

    // R7 oldest override, arising in the same cycle as a class expiry
    cfg_default(); cfg_old_thr = 8'd4; cfg_pri_map = 16'h0040; cfg_thr0 = 8'd1; do_reset();
    push(4'd8, 8'h00, 3'd7);
    push(4'd9, 8'h00, 3'd3);
    wait_cyc(1);
    chk("R7", gnt_tag, 9);
    chk("R7", gnt_kind, 1);
    wait_cyc(1);
    chk("R7", gnt_tag, 9);
    wait_cyc(1);
    chk("R7", gnt_tag, 8);
    chk("R7", gnt_kind, 2);

    // R8 unclassed entry never expires even with zero thresholds
    cfg_default(); cfg_thr0 = 8'd0; cfg_thr1 = 8'd0; do_reset();
    push(4'd1, 8'h00, 3'd7);
    push(4'd2, 8'h00, 3'd0);
    wait_cyc(20);
    chk("R8", gnt_tag, 2);
    chk("R8", gnt_kind, 0);

    // R10 full queue drops enqueue; drain in order
    cfg_default(); do_reset();
    for (int i = 0; i < 8; i++) push(4'(i), 8'h00, 3'd5);
    chk("R10", enq_ready, 0);
    push(4'd15, 8'h00, 3'd0);
    chk("R10", gnt_tag, 0);
    gnt_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      chk("R10", gnt_tag, i);
      @(posedge clk);
      @(negedge clk);
    end
    gnt_ready = 1'b0;
    chk("R10", gnt_valid, 0);

    // R11 wait counter saturates rather than wrapping
    cfg_default(); do_reset();
    push(4'd3, 8'h00, 3'd7);
    push(4'd4, 8'h00, 3'd0);
    wait_cyc(300);
    chk("R11", gnt_tag, 3);
    chk("R11", gnt_kind, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule